// File: doc/BRIEF.md
# One-Time-Programmable Region Controller

This block holds a small one-time-programmable region: 64 user bytes plus one control byte at offset 64. All 65 bytes sit in registers for simulation. A serial front end decodes the commands and passes them in as pulses: a write-enable pulse, a program session (start with an offset, a stream of data bytes, then an end strobe) and a read session (start with an offset, then one advance pulse per byte consumed). The front end also collects the address and dummy bytes before it raises these pulses.

A program session collects its bytes into a staging mask. The mask is folded into the region when the session ends. A bit can only go from 1 to 0, because each byte is combined by bitwise AND. Clearing bit 0 of the control byte locks the region for good, and from then on all 64 data bytes are frozen. A session is accepted only while the write-enable latch is set and no program cycle is busy. Ending a session clears the latch. An accepted commit starts a busy window of a fixed number of cycles.

Top module: `otp_region`

## Requirements
- R1: After reset, all 65 bytes read FFh, and `wel_o`, `wip_o` and `locked_o` are 0.
- R2: A `wren_i` pulse sets `wel_o` to 1. A program session started while `wel_o` is 0 changes no byte and does not raise `wip_o`.
- R3: An accepted session stores old AND new at each offset, starting at the given offset and advancing by one per data byte. The bytes land at the clock edge of `prog_end_i`, and `wel_o` is 0 from then on.
- R4: After an accepted, unlocked commit, `wip_o` is high for exactly BUSY_CYCLES consecutive cycles, starting the cycle after the `prog_end_i` edge.
- R5: A `prog_start_i` while `wip_o` is 1 starts no session. Its data changes no byte, and its end strobe leaves `wel_o` as it was.
- R6: `locked_o` is 1 exactly when bit 0 of the byte at offset 64 is 0. Once set, it stays set. While it is set, a session changes no byte and raises no `wip_o`, but its end still clears `wel_o`.
- R7: During a program session, data bytes whose offset would be above 64 are dropped, including every byte of a session whose start offset is above 64.
- R8: After a `rd_start_i` edge, `rd_data_o` shows the byte at the given offset. Each `rd_next_i` edge moves it to the next offset.
- R9: A read advancing from offset 64 goes to offset 0, and a read start offset above 64 begins at offset 0.
- R10: Programming FFh over a byte leaves it unchanged, and no bit ever returns from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_i | input | 1 | Write-enable command pulse |
| prog_start_i | input | 1 | Opens a program session at `addr_i` |
| rd_start_i | input | 1 | Opens a read at `addr_i` |
| addr_i | input | ADDR_W | Start offset for either session |
| data_valid_i | input | 1 | One program data byte is present |
| data_i | input | 8 | Program data byte |
| prog_end_i | input | 1 | Closes the program session |
| rd_next_i | input | 1 | Advances the read pointer |
| rd_data_o | output | 8 | Byte at the read pointer |
| wel_o | output | 1 | Write-enable latch |
| wip_o | output | 1 | Program cycle in progress |
| locked_o | output | 1 | Region permanently locked |

## Verification
The bench aims at these corner cases:
- The lock byte itself. A design that tested the lock after the commit instead of before would reject the very session that sets the lock. A design that allowed writes after locking would still alter the data bytes.
- Sessions that run past offset 64, and a start offset above 64. A design that wrapped the program pointer would corrupt offset 0.
- Reads crossing offset 64. A design that wrapped at 63 or 127 would return the wrong byte.
- A second program attempt during the busy window, and reprogramming with FFh and overlapping values. A design that stored the incoming byte instead of the AND would bring cleared bits back to 1.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t ERASED_BYTE = 8'hFF;
  localparam int    LOCK_BIT    = 0;
endpackage

// File: rtl/otp_busy_timer.sv
module otp_busy_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start_i)             cnt_d = CNT_W'(CYCLES);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int TOTAL = 65,
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stage_clr_i,
  input  logic             stage_we_i,
  input  logic [PTR_W-1:0] stage_idx_i,
  input  byte_t            stage_byte_i,
  input  logic             commit_i,
  output byte_t            mem_o [TOTAL]
);
  for (genvar g = 0; g < TOTAL; g++) begin : g_cell
    byte_t cell_q, cell_d, mask_q, mask_d;
    logic  mask_en;
    logic  hit;

    assign hit = stage_we_i && (stage_idx_i == PTR_W'(g));

    always_comb begin
      cell_d  = cell_q & mask_q;
      mask_en = stage_clr_i || hit;
      mask_d  = stage_clr_i ? ERASED_BYTE : (mask_q & stage_byte_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= ERASED_BYTE;
        mask_q <= ERASED_BYTE;
      end else begin
        if (commit_i) cell_q <= cell_d;
        if (mask_en)  mask_q <= mask_d;
      end
    end

    assign mem_o[g] = cell_q;
  end
endmodule

// File: rtl/otp_region.sv
module otp_region
  import otp_pkg::*;
#(
  parameter int DATA_BYTES  = 64,
  parameter int ADDR_W      = 24,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_i,
  input  logic              prog_start_i,
  input  logic              rd_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [7:0]        data_i,
  input  logic              prog_end_i,
  input  logic              rd_next_i,
  output logic [7:0]        rd_data_o,
  output logic              wel_o,
  output logic              wip_o,
  output logic              locked_o
);
  localparam int TOTAL    = DATA_BYTES + 1;
  localparam int PTR_W    = $clog2(TOTAL + 1);
  localparam int LOCK_IDX = DATA_BYTES;
  localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(TOTAL);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DATA_BYTES);

  byte_t            mem [TOTAL];
  logic             wel_q, wel_d;
  logic             sess_q, sess_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic             stage_clr, stage_we, commit;
  logic             accept, addr_ok, locked;

  assign addr_ok = (addr_i <= ADDR_W'(DATA_BYTES));
  assign locked  = ~mem[LOCK_IDX][LOCK_BIT];
  assign accept  = prog_start_i && wel_q && !wip_o;

  always_comb begin
    wel_d     = wel_q;
    sess_d    = sess_q;
    ptr_d     = ptr_q;
    rd_ptr_d  = rd_ptr_q;
    stage_clr = 1'b0;
    stage_we  = 1'b0;
    commit    = 1'b0;

    if (wren_i) wel_d = 1'b1;

    if (accept) begin
      sess_d    = 1'b1;
      stage_clr = 1'b1;
      ptr_d     = addr_ok ? addr_i[PTR_W-1:0] : PTR_END;
    end else if (sess_q) begin
      if (data_valid_i && (ptr_q != PTR_END)) begin
        stage_we = 1'b1;
        ptr_d    = ptr_q + 1'b1;
      end
      if (prog_end_i) begin
        sess_d = 1'b0;
        wel_d  = 1'b0;
        commit = !locked;
      end
    end

    if (rd_start_i)
      rd_ptr_d = addr_ok ? addr_i[PTR_W-1:0] : '0;
    else if (rd_next_i)
      rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q    <= 1'b0;
      sess_q   <= 1'b0;
      ptr_q    <= '0;
      rd_ptr_q <= '0;
    end else begin
      wel_q  <= wel_d;
      sess_q <= sess_d;
      if (accept || sess_q)           ptr_q    <= ptr_d;
      if (rd_start_i || rd_next_i)    rd_ptr_q <= rd_ptr_d;
    end
  end

  otp_store #(
    .TOTAL (TOTAL),
    .PTR_W (PTR_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .stage_clr_i  (stage_clr),
    .stage_we_i   (stage_we),
    .stage_idx_i  (ptr_q),
    .stage_byte_i (data_i),
    .commit_i     (commit),
    .mem_o        (mem)
  );

  otp_busy_timer #(
    .CYCLES (BUSY_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (commit),
    .busy_o  (wip_o)
  );

  assign rd_data_o = mem[rd_ptr_q];
  assign wel_o     = wel_q;
  assign locked_o  = locked;
endmodule

// File: rtl/otp_region_chk.sv
module otp_region_chk
  import otp_pkg::*;
#(
  parameter int DATA_BYTES = 64,
  parameter int PTR_W      = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prog_end_i,
  input logic             rd_start_i,
  input logic             rd_next_i,
  input logic             wel_o,
  input logic             wip_o,
  input logic             locked_o,
  input logic             sess_q,
  input logic [PTR_W-1:0] rd_ptr_q,
  input byte_t            mem [DATA_BYTES+1]
);
  AST_WIP_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> $past(wel_o)); // R2

  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    sess_q && prog_end_i |=> !wel_o); // R3

  AST_BUSY_BLOCKS_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    wip_o && !sess_q |=> !sess_q); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |=> locked_o); // R6

  AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_next_i && !rd_start_i && (rd_ptr_q == PTR_W'(DATA_BYTES)) |=> rd_ptr_q == '0); // R9

  for (genvar g = 0; g <= DATA_BYTES; g++) begin : g_bytes
    AST_BIT_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem[g] & ~$past(mem[g])) == 8'h00); // R10
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_frozen
    AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked_o) |-> $stable(mem[g])); // R6
  end
endmodule

bind otp_region otp_region_chk #(
  .DATA_BYTES (DATA_BYTES),
  .PTR_W      (PTR_W)
) u_otp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prog_end_i (prog_end_i),
  .rd_start_i (rd_start_i),
  .rd_next_i  (rd_next_i),
  .wel_o      (wel_o),
  .wip_o      (wip_o),
  .locked_o   (locked_o),
  .sess_q     (sess_q),
  .rd_ptr_q   (rd_ptr_q),
  .mem        (mem)
);

// File: tb/otp_region_bench.sv
module otp_region_bench;
  localparam int DATA_BYTES  = 64;
  localparam int ADDR_W      = 24;
  localparam int BUSY_CYCLES = 16;
  localparam int TOTAL       = DATA_BYTES + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wren_i = 1'b0, prog_start_i = 1'b0, rd_start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              data_valid_i = 1'b0;
  logic [7:0]        data_i = '0;
  logic              prog_end_i = 1'b0, rd_next_i = 1'b0;
  logic [7:0]        rd_data_o;
  logic              wel_o, wip_o, locked_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [TOTAL];
  logic [7:0] pbuf [16];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       mon_en = 1'b0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  otp_region #(
    .DATA_BYTES  (DATA_BYTES),
    .ADDR_W      (ADDR_W),
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_otp_region (
    .clk (clk), .rst_n (rst_n), .wren_i (wren_i), .prog_start_i (prog_start_i),
    .rd_start_i (rd_start_i), .addr_i (addr_i), .data_valid_i (data_valid_i),
    .data_i (data_i), .prog_end_i (prog_end_i), .rd_next_i (rd_next_i),
    .rd_data_o (rd_data_o), .wel_o (wel_o), .wip_o (wip_o), .locked_o (locked_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: compares the read byte away from the edge
  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string      t = tag_q.pop_front();
      check(rd_data_o === e, t, rd_data_o, e);
    end
  end

  task automatic do_wren();
    wren_i = 1'b1; tick(); wren_i = 1'b0;
  endtask

  task automatic do_prog(input int addr, input int n);
    prog_start_i = 1'b1; addr_i = ADDR_W'(addr); tick(); prog_start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      data_valid_i = 1'b1; data_i = pbuf[i]; tick();
    end
    data_valid_i = 1'b0;
    prog_end_i = 1'b1; tick(); prog_end_i = 1'b0;
  endtask

  task automatic model_apply(input int addr, input int n);
    for (int i = 0; i < n; i++)
      if (addr + i <= DATA_BYTES) model[addr + i] &= pbuf[i];
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (wip_o && guard < 1000) begin tick(); guard++; end
  endtask

  // Driver: pushes expected bytes from the bench model, monitor pops them
  task automatic do_read(input int addr, input int n, input string tag);
    int p;
    p = (addr > DATA_BYTES) ? 0 : addr;
    rd_start_i = 1'b1; addr_i = ADDR_W'(addr); tick(); rd_start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[p]); tag_q.push_back(tag);
      mon_en = 1'b1; rd_next_i = 1'b1;
      tick();
      p = (p == DATA_BYTES) ? 0 : p + 1;
    end
    rd_next_i = 1'b0; mon_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < TOTAL; i++) model[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1: reset state, full sweep; R9: 66th byte wraps to offset 0
    check(wel_o == 1'b0, "R1 wel", wel_o, 0);
    check(wip_o == 1'b0, "R1 wip", wip_o, 0);
    check(locked_o == 1'b0, "R1 locked", locked_o, 0);
    do_read(0, TOTAL, "R1 erased");
    do_read(DATA_BYTES, 2, "R9 wrap 64->0");

    // R2: program without write enable is ignored
    pbuf[0] = 8'h00;
    do_prog(0, 1);
    check(wip_o == 1'b0, "R2 no wip", wip_o, 0);
    do_read(0, 1, "R2 ignored");

    // R2/R3/R4: accepted program
    do_wren();
    check(wel_o == 1'b1, "R2 wel set", wel_o, 1);
    pbuf[0] = 8'hA5; pbuf[1] = 8'h3C; pbuf[2] = 8'hF0;
    do_prog(5, 3); model_apply(5, 3);
    check(wel_o == 1'b0, "R3 wel cleared", wel_o, 0);
    n = 0;
    while (wip_o && n < 1000) begin n++; tick(); end
    check(n == BUSY_CYCLES, "R4 busy length", n, BUSY_CYCLES);
    do_read(5, 3, "R3 and-store");
    do_read(4, 1, "R8 neighbour");

    // R10: FF keeps, overlap ANDs
    do_wren();
    pbuf[0] = 8'h5A; pbuf[1] = 8'hFF; pbuf[2] = 8'h0F;
    do_prog(5, 3); model_apply(5, 3); wait_idle();
    do_read(5, 3, "R10 no bit returns");

    // R5: request during busy is ignored, latch kept
    do_wren();
    pbuf[0] = 8'h00;
    do_prog(10, 1); model_apply(10, 1);
    check(wip_o == 1'b1, "R5 busy", wip_o, 1);
    do_wren();
    pbuf[0] = 8'h00;
    do_prog(11, 1);
    check(wel_o == 1'b1, "R5 wel kept", wel_o, 1);
    wait_idle();
    do_read(10, 2, "R5 ignored during busy");
    pbuf[0] = 8'h77;
    do_prog(12, 1); model_apply(12, 1); wait_idle();
    do_read(12, 1, "R5 later accepted");

    // R7: overflow past 64 dropped; R9 read wrap
    do_wren();
    pbuf[0] = 8'h11; pbuf[1] = 8'h22; pbuf[2] = 8'h33; pbuf[3] = 8'h44; pbuf[4] = 8'h55;
    do_prog(62, 5); model_apply(62, 5); wait_idle();
    check(locked_o == 1'b0, "R7 not locked", locked_o, 0);
    do_read(62, 4, "R7 tail dropped");
    do_wren();
    pbuf[0] = 8'h00;
    do_prog(100, 1); wait_idle();
    do_read(100, 1, "R9 far start");
    do_read(0, TOTAL, "R7 far program dropped");

    // R6: lock
    do_wren();
    pbuf[0] = 8'hFE;
    do_prog(DATA_BYTES, 1); model_apply(DATA_BYTES, 1);
    check(locked_o == 1'b1, "R6 locked", locked_o, 1);
    wait_idle();
    do_wren();
    pbuf[0] = 8'h00; pbuf[1] = 8'h00;
    do_prog(0, 2);
    check(wel_o == 1'b0, "R6 wel cleared", wel_o, 0);
    check(wip_o == 1'b0, "R6 no wip", wip_o, 0);
    do_read(0, 2, "R6 frozen");
    do_read(60, 5, "R6 frozen tail");
    check(locked_o == 1'b1, "R6 sticky", locked_o, 1);

    tick();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule